// File: doc/BRIEF.md
# Multi-Size Page Translation Buffer

This block is a fully associative buffer that caches virtual-to-physical address translations for a 32-bit address space. Each of its slots (32 by default) holds one translation whose region can be a 1 MB section, a 64 KB large page or a 4 KB small page. The size recorded in a slot decides how many upper address bits take part in the tag compare and how many are replaced by the physical tag; the rest of the address passes through unchanged.

A lookup port returns hit, physical address and access permissions one clock after the request. New translations come in through a fill port and land in the slot named by a round-robin pointer. Before a fill is written, every resident entry whose region overlaps the new one is dropped, so no address ever matches two slots. Maintenance inputs clear the whole buffer or, where the instance allows it, only the slot that maps a given address. Separate instances serve the instruction and the data stream. The parameter `SINGLE_FLUSH_EN` is cleared for the instruction-side instance, and that removes its per-address invalidation.

Top module: `xlat_buffer`

## Requirements
- R1: After a synchronous reset every slot is empty: each lookup misses and `lk_hit` is 0.
- R2: A lookup sampled with `lk_req` high at a rising edge shows its result on `lk_hit`, `lk_pa` and `lk_perm` right after that edge. In a cycle that follows an edge without `lk_req`, `lk_hit` is 0.
- R3: `fill_size` is coded as 01 = 1 MB section (compares and replaces VA[31:20]), 10 = 64 KB large page (VA[31:16]) and 11 = 4 KB small page (VA[31:12]). `fill_vpn` and `fill_ppn` carry address bits [31:12]. The tag bits below the region size are ignored, and on a hit the low VA bits pass into `lk_pa` unchanged.
- R4: A fill writes the slot that the round-robin pointer names and then moves the pointer up by one, from the last slot back to 0. Counting from reset, fill number 33 therefore evicts the first translation. A fill with `fill_size` 00 is ignored.
- R5: A fill invalidates every valid entry whose region overlaps the new region. No VA matches more than one entry, and a refill of the same page replaces the old translation. If several entries ever match, the lowest index wins.
- R6: `flush_all` empties every slot and leaves the round-robin pointer unchanged. A fill or single flush in the same cycle is dropped.
- R7: With `SINGLE_FLUSH_EN`=1, `flush_one` invalidates only the entry that maps `flush_vpn`, and all other entries stay. A fill in the same cycle is still written.
- R8: With `SINGLE_FLUSH_EN`=0, `flush_one` has no effect.
- R9: A lookup in the same cycle as a fill or flush sees the contents from before that update.
- R10: On a hit, `lk_perm` returns the permission bits stored by the fill. On a miss it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | 32 | Registered physical address (0 on miss) |
| lk_perm | output | 4 | Registered permissions (0 on miss) |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | 20 | Virtual address bits [31:12] of the fill |
| fill_ppn | input | 20 | Physical address bits [31:12] of the fill |
| fill_size | input | 2 | Region size code of the fill |
| fill_perm | input | 4 | Permission bits of the fill |
| flush_all | input | 1 | Invalidate all entries |
| flush_one | input | 1 | Invalidate the entry that maps flush_vpn |
| flush_vpn | input | 20 | Virtual address bits [31:12] for flush_one |

## Verification
The only latency in the block is one cycle on the lookup path. Updates from fills and flushes are written at the edge where they are sampled. The bench drives every input on a falling edge, holds it across exactly one rising edge and reads the lookup outputs on the next falling edge, which lies half a period after the edge that registers them. A lookup issued in the cycle after an update therefore sees that update, while a lookup issued together with the update sees the contents from before it. Eviction order is checked by counting fills, so the victim expected after 32 fills is known without reading the pointer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int PG_SH   = 12;
    localparam int TAG_W   = VA_W - PG_SH;
    localparam int PERM_W  = 4;

    typedef enum logic [1:0] {
        SZ_NONE  = 2'b00,
        SZ_SECT  = 2'b01,
        SZ_LARGE = 2'b10,
        SZ_SMALL = 2'b11
    } pg_size_e;

    typedef struct packed {
        pg_size_e            size;
        logic [TAG_W-1:0]    vtag;
        logic [TAG_W-1:0]    ptag;
        logic [PERM_W-1:0]   perm;
    } xlat_rec_t;

    // tag bits that take part in compare and replacement for one size
    function automatic logic [TAG_W-1:0] tag_mask(pg_size_e s);
        case (s)
            SZ_SECT:  tag_mask = {{(TAG_W-8){1'b1}}, 8'h00};
            SZ_LARGE: tag_mask = {{(TAG_W-4){1'b1}}, 4'h0};
            SZ_SMALL: tag_mask = {TAG_W{1'b1}};
            default:  tag_mask = '0;
        endcase
    endfunction

    function automatic logic tag_hit(xlat_rec_t r, logic [TAG_W-1:0] t);
        tag_hit = (r.size != SZ_NONE) && (((r.vtag ^ t) & tag_mask(r.size)) == '0);
    endfunction

    // two regions overlap when they agree on the bits of the coarser one
    function automatic logic regions_meet(xlat_rec_t a, xlat_rec_t b);
        regions_meet = (a.size != SZ_NONE) && (b.size != SZ_NONE) &&
                       (((a.vtag ^ b.vtag) & tag_mask(a.size) & tag_mask(b.size)) == '0);
    endfunction

    function automatic logic [VA_W-1:0] xlate(xlat_rec_t r, logic [VA_W-1:0] va);
        logic [TAG_W-1:0] m;
        m = tag_mask(r.size);
        xlate = {(r.ptag & m) | (va[VA_W-1:PG_SH] & ~m), va[PG_SH-1:0]};
    endfunction

endpackage

// File: rtl/xlat_rr_ptr.sv
module xlat_rr_ptr
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_go,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (fill_go)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    a_r6_ptr_keep: assert property (@(posedge clk) disable iff (rst)
        !fill_go |=> $stable(ptr));

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter bit SINGLE_FLUSH_EN = 1'b1,
    localparam int IDX_W = $clog2(ENTRIES)
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [VA_W-1:0]           lk_va,
    input  logic                      fill_go,
    input  logic [IDX_W-1:0]          fill_idx,
    input  xlat_rec_t                 fill_rec,
    input  logic                      flush_all,
    input  logic                      flush_one,
    input  logic [TAG_W-1:0]          flush_vpn,
    output logic [ENTRIES-1:0]        match_vec,
    output xlat_rec_t [ENTRIES-1:0]   recs
);
    logic [ENTRIES-1:0] valid_vec;
    logic               one_go;

    assign one_go = SINGLE_FLUSH_EN && flush_one && !flush_all;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic kill;

        assign match_vec[i] = tag_hit(recs[i], lk_va[VA_W-1:PG_SH]);
        assign valid_vec[i] = (recs[i].size != SZ_NONE);
        assign kill = (fill_go && regions_meet(recs[i], fill_rec)) ||
                      (one_go && tag_hit(recs[i], flush_vpn));

        always_ff @(posedge clk) begin
            if (rst || flush_all) begin
                recs[i] <= '0;
            end else if (fill_go && fill_idx == IDX_W'(i)) begin
                recs[i] <= fill_rec;
            end else if (kill) begin
                recs[i].size <= SZ_NONE;
            end
        end
    end

    a_r8_single_flush_off: assert property (@(posedge clk) disable iff (rst)
        (!SINGLE_FLUSH_EN && flush_one && !flush_all && !fill_go) |=> $stable(valid_vec));

    a_r7_flush_one_clears: assert property (@(posedge clk) disable iff (rst)
        (one_go && !fill_go) |=> ((valid_vec & ~$past(valid_vec)) == '0));

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      lk_req,
    input  logic [VA_W-1:0]           lk_va,
    input  logic [ENTRIES-1:0]        match_vec,
    input  xlat_rec_t [ENTRIES-1:0]   recs,
    output logic                      lk_hit,
    output logic [VA_W-1:0]           lk_pa,
    output logic [PERM_W-1:0]         lk_perm
);
    logic      found;
    xlat_rec_t sel;

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                found = 1'b1;
                sel   = recs[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_hit  <= 1'b0;
            lk_pa   <= '0;
            lk_perm <= '0;
        end else begin
            lk_hit  <= lk_req && found;
            lk_pa   <= (lk_req && found) ? xlate(sel, lk_va) : '0;
            lk_perm <= (lk_req && found) ? sel.perm : '0;
        end
    end

    a_r2_idle_miss: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_hit);

    a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_perm == '0 && lk_pa == '0));

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter bit SINGLE_FLUSH_EN = 1'b1
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_req,
    input  logic [VA_W-1:0]     lk_va,
    output logic                lk_hit,
    output logic [VA_W-1:0]     lk_pa,
    output logic [PERM_W-1:0]   lk_perm,
    input  logic                fill_en,
    input  logic [TAG_W-1:0]    fill_vpn,
    input  logic [TAG_W-1:0]    fill_ppn,
    input  logic [1:0]          fill_size,
    input  logic [PERM_W-1:0]   fill_perm,
    input  logic                flush_all,
    input  logic                flush_one,
    input  logic [TAG_W-1:0]    flush_vpn
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic                      fill_go;
    logic [IDX_W-1:0]          victim;
    xlat_rec_t                 fill_rec;
    logic [ENTRIES-1:0]        match_vec;
    xlat_rec_t [ENTRIES-1:0]   recs;
    logic [ENTRIES-1:0]        occupied;

    assign fill_go  = fill_en && (fill_size != 2'b00) && !flush_all;
    assign fill_rec = '{size: pg_size_e'(fill_size), vtag: fill_vpn,
                        ptag: fill_ppn, perm: fill_perm};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_occ
        assign occupied[i] = (recs[i].size != SZ_NONE);
    end

    xlat_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .fill_go (fill_go),
        .ptr     (victim)
    );

    xlat_store #(.ENTRIES(ENTRIES), .SINGLE_FLUSH_EN(SINGLE_FLUSH_EN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_va     (lk_va),
        .fill_go   (fill_go),
        .fill_idx  (victim),
        .fill_rec  (fill_rec),
        .flush_all (flush_all),
        .flush_one (flush_one),
        .flush_vpn (flush_vpn),
        .match_vec (match_vec),
        .recs      (recs)
    );

    xlat_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .lk_req    (lk_req),
        .lk_va     (lk_va),
        .match_vec (match_vec),
        .recs      (recs),
        .lk_hit    (lk_hit),
        .lk_pa     (lk_pa),
        .lk_perm   (lk_perm)
    );

    a_r5_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    a_r6_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (occupied == '0));

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (occupied == '0 && !lk_hit));

endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush_all = 1'b0;
    logic        flush_one = 1'b0;
    logic [19:0] flush_vpn = '0;

    logic        d_hit, i_hit;
    logic [31:0] d_pa, i_pa;
    logic [3:0]  d_perm, i_perm;

    int n_run = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    xlat_buffer #(.ENTRIES(32), .SINGLE_FLUSH_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va),
        .lk_hit(d_hit), .lk_pa(d_pa), .lk_perm(d_perm),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_size(fill_size), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn));

    xlat_buffer #(.ENTRIES(32), .SINGLE_FLUSH_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va),
        .lk_hit(i_hit), .lk_pa(i_pa), .lk_perm(i_perm),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_size(fill_size), .fill_perm(fill_perm),
        .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn));

    function automatic logic [31:0] want_pa(logic [31:0] va, logic [31:0] pbase, logic [1:0] sz);
        logic [31:0] span;
        span = (sz == 2'b01) ? 32'h0010_0000 : (sz == 2'b10) ? 32'h0001_0000 : 32'h0000_1000;
        return (pbase - (pbase % span)) + (va % span);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz, input logic [3:0] pm);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = va[31:12]; fill_ppn = pa[31:12];
        fill_size = sz; fill_perm = pm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // issue one lookup; outputs checked half a period after the registering edge
    task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] epa,
                        input logic [3:0] epm, input string req);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va;
        @(negedge clk);
        lk_req = 1'b0;
        chk(d_hit == eh, req, {31'd0, d_hit}, {31'd0, eh});
        if (eh) begin
            chk(d_pa == epa, req, d_pa, epa);
            chk(d_perm == epm, req, {28'd0, d_perm}, {28'd0, epm});
        end else begin
            chk(d_perm == 4'd0, req, {28'd0, d_perm}, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: empty after reset, no hit without a request
        @(negedge clk);
        chk(d_hit == 1'b0, "R2 idle", {31'd0, d_hit}, 32'd0);
        look(32'h4000_0000, 1'b0, '0, '0, "R1 empty after reset");

        // R4 / R3 / R10: fill all 32 slots with small pages and read each back
        for (int i = 0; i < 32; i++)
            put(32'h4000_0000 + (i << 12), 32'h8000_0000 + ((i * 3) << 12), 2'b11, 4'(i));
        for (int i = 0; i < 32; i++) begin
            logic [31:0] va;
            va = 32'h4000_0000 + (i << 12) + ((i * 37) % 4096);
            look(va, 1'b1, want_pa(va, 32'h8000_0000 + ((i * 3) << 12), 2'b11), 4'(i),
                 "R4 R10 sweep small pages");
        end

        // R4: fill 33 evicts the first translation, fill 34 the second
        put(32'h5000_0000, 32'h9000_0000, 2'b11, 4'hA);
        look(32'h4000_0010, 1'b0, '0, '0, "R4 first victim evicted");
        look(32'h4000_1010, 1'b1, 32'h8000_3010, 4'd1, "R4 second entry kept");
        look(32'h5000_0444, 1'b1, 32'h9000_0444, 4'hA, "R4 new entry");
        put(32'h5000_1000, 32'h9000_1000, 2'b11, 4'hB);
        look(32'h4000_1010, 1'b0, '0, '0, "R4 next victim in order");

        // R9: lookup with flush_all in the same cycle sees old contents
        @(negedge clk);
        flush_all = 1'b1; lk_req = 1'b1; lk_va = 32'h4000_5000;
        @(negedge clk);
        flush_all = 1'b0; lk_req = 1'b0;
        chk(d_hit == 1'b1, "R9 pre-update lookup", {31'd0, d_hit}, 32'd1);
        chk(d_pa == 32'h8000_F000, "R9 pre-update pa", d_pa, 32'h8000_F000);

        // R6: everything gone afterwards
        for (int i = 0; i < 32; i++)
            look(32'h4000_0000 + (i << 12), 1'b0, '0, '0, "R6 flush_all empties");

        // R6: fill together with flush_all is dropped
        @(negedge clk);
        flush_all = 1'b1; fill_en = 1'b1; fill_vpn = 20'h6000_0; fill_ppn = 20'h7000_0;
        fill_size = 2'b11; fill_perm = 4'h3;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        look(32'h6000_0000, 1'b0, '0, '0, "R6 concurrent fill dropped");

        // R3: each size code
        put(32'h1230_0000, 32'hABC0_0000, 2'b01, 4'h5);
        look(32'h1234_5678, 1'b1, 32'hABC4_5678, 4'h5, "R3 section");
        look(32'h123F_FFFC, 1'b1, 32'hABCF_FFFC, 4'h5, "R3 section top");
        look(32'h1240_0000, 1'b0, '0, '0, "R3 section outside");
        put(32'h2222_0000, 32'h7777_0000, 2'b10, 4'h6);
        look(32'h2222_ABCD, 1'b1, 32'h7777_ABCD, 4'h6, "R3 large page");
        look(32'h2223_0000, 1'b0, '0, '0, "R3 large outside");
        put(32'h3333_3000, 32'h4444_4000, 2'b11, 4'h7);
        look(32'h3333_3FFF, 1'b1, 32'h4444_4FFF, 4'h7, "R3 small page");
        look(32'h3333_4000, 1'b0, '0, '0, "R3 small outside");

        // R5: a small page inside the section removes the section
        put(32'h1235_5000, 32'hC000_0000, 2'b11, 4'h8);
        look(32'h1234_5678, 1'b0, '0, '0, "R5 overlap removed");
        look(32'h1235_5ABC, 1'b1, 32'hC000_0ABC, 4'h8, "R5 new small page");
        put(32'h1235_5000, 32'hD000_0000, 2'b11, 4'h9);
        look(32'h1235_5ABC, 1'b1, 32'hD000_0ABC, 4'h9, "R5 refill replaces");

        // R7 / R8: single flush of the large page
        @(negedge clk);
        flush_one = 1'b1; flush_vpn = 20'h22221;
        @(negedge clk);
        flush_one = 1'b0;
        look(32'h2222_0100, 1'b0, '0, '0, "R7 single flush removes");
        chk(i_hit == 1'b1, "R8 instr side ignores single flush", {31'd0, i_hit}, 32'd1);
        chk(i_pa == 32'h7777_0100, "R8 instr side pa", i_pa, 32'h7777_0100);
        look(32'h3333_3004, 1'b1, 32'h4444_4004, 4'h7, "R7 other entry kept");

        // R4: size 00 fill is ignored, resident entry stays
        put(32'h3333_3000, 32'h0, 2'b00, 4'h0);
        look(32'h3333_3008, 1'b1, 32'h4444_4008, 4'h7, "R4 size 00 ignored");

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule